// File: doc/BRIEF.md
# Periodic USB Transaction Bus-Time Calculator

This block works out how much bus time one periodic USB transaction takes up. An interrupt or isochronous endpoint request goes in, and a cost in byte-times comes out. A scheduler then compares that cost with the budget left in a frame or microframe. The cost is more than the payload length. It adds the protocol overhead for the device speed and the transfer type, an allowance of seven sixths of the payload for bit stuffing, and an eight-fold penalty on the payload for the slow low-speed clock. It also adds a programmable host turnaround delay, and the cost of each phase of a split transaction that a high-speed hub carries for a full- or low-speed device.

Each request is presented for one cycle with its valid bit set. The answer appears two cycles later, together with a one-cycle valid strobe and an error flag. The host turnaround delay is held in a small register that software-visible logic elsewhere can rewrite. Its value after reset is 18 byte-times.

Top module: `usb_bw_cost_calc`

## Requirements
- R1: A request accepted on a rising edge gives `cost_valid` high for exactly one cycle, after the second rising edge. While `cost_valid` is low, `cost_bytes` is 0 and `cost_err` is 0.
- R2: Full speed (`req_speed`=0), not split: cost = OV + floor(MPS*7/6) + HD. OV is 14 for plain transfers (`req_xfer`=0), 10 for isochronous OUT (`req_xfer`=1) and 11 for isochronous IN (`req_xfer`=2).
- R3: Low speed (`req_speed`=1), not split: cost = 98 + 8*floor(MPS*7/6) + HD. The 98 is 97 of low-speed overhead plus 1 for the hub port.
- R4: High speed (`req_speed`=2): cost = (OV + floor(MPS*7/6) + HD) * `req_ntrans`. OV is 55 for plain transfers and 38 for isochronous transfers.
- R5: A split request (`req_split`=1 for the start phase, 2 for the complete phase) from a full- or low-speed device that moves data device-to-host has these costs. The start phase costs OVH + HD + 4. The complete phase costs OVH + floor(MPS*7/6) + HD + 4. OVH is the high-speed overhead from R4. A transfer is device-to-host when `req_xfer`=2, or when `req_xfer`=0 and `req_dir_in`=1.
- R6: A host-to-device split charges the payload term to the start phase and leaves it out of the complete phase. Each phase still adds 4.
- R7: floor(MPS*7/6) is exact for every 11-bit MPS, from 0 to 2047.
- R8: The host-delay register HD is 18 after reset. A write takes effect for requests presented after the write cycle. A request presented in the same cycle as a write uses the old value.
- R9: These requests return `cost_err`=1 and `cost_bytes`=0: speed 3, transfer type 3, split code 3, low-speed isochronous, high speed with a nonzero split code, and high speed with `req_ntrans`=0.
- R10: `req_ntrans` has no effect unless the request is high speed. `req_dir_in` has no effect on requests that are not split, and none on isochronous requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_wr_en | input | 1 | Write strobe for the host-delay register |
| hd_wr_data | input | 8 | New host delay, in byte-times |
| req_valid | input | 1 | Request present this cycle |
| req_speed | input | 2 | 0 full, 1 low, 2 high |
| req_xfer | input | 2 | 0 plain, 1 isochronous OUT, 2 isochronous IN |
| req_split | input | 2 | 0 none, 1 start phase, 2 complete phase |
| req_dir_in | input | 1 | Direction of a plain split (1 = device-to-host) |
| req_ntrans | input | 2 | High-speed transactions per microframe, 1 to 3 |
| req_mps | input | 11 | Maximum packet size in bytes |
| cost_valid | output | 1 | Result strobe |
| cost_err | output | 1 | Illegal request flag |
| cost_bytes | output | 16 | Cost in byte-times |

## Verification
A host-delay write and a cost request can arrive in the same cycle. When they do, the request must be priced with the old delay, and only requests that come later see the new one. The bench provokes this on purpose in directed steps. It also raises it at random, by mixing writes into the random request stream on the same edge as a request. A reference model prices each request with the delay value that was in force before the write, and checks the next request against the new value.

// File: rtl/usb_bw_pkg.sv
package usb_bw_pkg;

  typedef enum logic [1:0] {
    SPD_FULL = 2'd0,
    SPD_LOW  = 2'd1,
    SPD_HIGH = 2'd2,
    SPD_BAD  = 2'd3
  } speed_e;

  typedef enum logic [1:0] {
    XF_PLAIN   = 2'd0,
    XF_ISO_OUT = 2'd1,
    XF_ISO_IN  = 2'd2,
    XF_BAD     = 2'd3
  } xfer_e;

  typedef enum logic [1:0] {
    SPL_NONE     = 2'd0,
    SPL_START    = 2'd1,
    SPL_COMPLETE = 2'd2,
    SPL_BAD      = 2'd3
  } split_e;

  // byte-time overheads
  localparam int unsigned FS_OVH_PLAIN   = 14;
  localparam int unsigned FS_OVH_ISO_OUT = 10;
  localparam int unsigned FS_OVH_ISO_IN  = 11;
  localparam int unsigned LS_OVH         = 97;
  localparam int unsigned LS_HUB_OVH     = 1;
  localparam int unsigned LS_CLK_MUL     = 8;
  localparam int unsigned HS_OVH_PLAIN   = 55;
  localparam int unsigned HS_OVH_ISO     = 38;
  localparam int unsigned SPLIT_OVH      = 4;
  localparam int unsigned HD_DEFAULT     = 18;

  // reciprocal of 6 scaled by 2^18, exact for dividends below 2^17
  localparam int unsigned RECIP6_MUL   = 43691;
  localparam int unsigned RECIP6_SHIFT = 18;

  typedef struct packed {
    logic       err;
    logic [7:0] base;     // fixed byte-time part
    logic [3:0] pay_mul;  // weight of the stuffed payload (0, 1 or 8)
    logic [1:0] rep;      // repeat count
  } cost_plan_t;

  function automatic int unsigned cost_sum(input int unsigned base,
                                           input int unsigned pay,
                                           input int unsigned pay_mul,
                                           input int unsigned hd,
                                           input int unsigned rep);
    return (base + pay * pay_mul + hd) * rep;
  endfunction

endpackage

// File: rtl/usb_bw_decode.sv
module usb_bw_decode
  import usb_bw_pkg::*;
(
  input  logic [1:0] speed,
  input  logic [1:0] xfer,
  input  logic [1:0] split,
  input  logic       dir_in,
  input  logic [1:0] ntrans,
  output cost_plan_t plan
);

  speed_e sp;
  xfer_e  xf;
  split_e spl;
  logic   is_iso;
  logic   to_host;
  logic   bad_code;
  logic   bad_combo;

  assign sp  = speed_e'(speed);
  assign xf  = xfer_e'(xfer);
  assign spl = split_e'(split);

  assign is_iso   = (xf == XF_ISO_OUT) || (xf == XF_ISO_IN);
  assign to_host  = (xf == XF_ISO_IN) || ((xf == XF_PLAIN) && dir_in);
  assign bad_code = (sp == SPD_BAD) || (xf == XF_BAD) || (spl == SPL_BAD);
  assign bad_combo = ((sp == SPD_LOW) && is_iso) ||
                     ((sp == SPD_HIGH) && (spl != SPL_NONE)) ||
                     ((sp == SPD_HIGH) && (ntrans == 2'd0));

  always_comb begin
    plan         = '0;
    plan.err     = bad_code || bad_combo;
    plan.rep     = 2'd1;
    plan.pay_mul = 4'd1;
    if (spl != SPL_NONE) begin
      plan.base = 8'((is_iso ? HS_OVH_ISO : HS_OVH_PLAIN) + SPLIT_OVH);
      // payload rides on the phase that carries data
      if ((spl == SPL_START && !to_host) || (spl == SPL_COMPLETE && to_host))
        plan.pay_mul = 4'd1;
      else
        plan.pay_mul = 4'd0;
    end else begin
      unique case (sp)
        SPD_HIGH: begin
          plan.base = 8'(is_iso ? HS_OVH_ISO : HS_OVH_PLAIN);
          plan.rep  = ntrans;
        end
        SPD_LOW: begin
          plan.base    = 8'(LS_OVH + LS_HUB_OVH);
          plan.pay_mul = 4'(LS_CLK_MUL);
        end
        default: begin
          case (xf)
            XF_ISO_OUT: plan.base = 8'(FS_OVH_ISO_OUT);
            XF_ISO_IN:  plan.base = 8'(FS_OVH_ISO_IN);
            default:    plan.base = 8'(FS_OVH_PLAIN);
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/usb_bw_stuff.sv
module usb_bw_stuff
  import usb_bw_pkg::*;
#(
  parameter int MPS_W = 11,
  localparam int PAY_W = MPS_W + 1
) (
  input  logic [MPS_W-1:0] mps,
  output logic [PAY_W-1:0] stuffed
);

  localparam int X7_W = MPS_W + 3;

  logic [X7_W-1:0] x7;
  assign x7 = {mps, 3'b000} - X7_W'(mps);

  generate
    if (MPS_W <= 14) begin : g_recip
      localparam int PROD_W = X7_W + 16;
      logic [PROD_W-1:0] prod;
      assign prod    = PROD_W'(x7) * PROD_W'(RECIP6_MUL);
      assign stuffed = PAY_W'(prod >> RECIP6_SHIFT);
    end else begin : g_div
      assign stuffed = PAY_W'(x7 / X7_W'(6));
    end
  endgenerate

endmodule

// File: rtl/usb_bw_hostdelay.sv
module usb_bw_hostdelay #(
  parameter int HD_W     = 8,
  parameter int HD_RESET = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [HD_W-1:0] wr_data,
  output logic [HD_W-1:0] delay_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     delay_q <= HD_W'(HD_RESET);
    else if (wr_en) delay_q <= wr_data;
  end

endmodule

// File: rtl/usb_bw_cost_calc.sv
module usb_bw_cost_calc
  import usb_bw_pkg::*;
#(
  parameter int MPS_W  = 11,
  parameter int HD_W   = 8,
  parameter int COST_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hd_wr_en,
  input  logic [HD_W-1:0]   hd_wr_data,
  input  logic              req_valid,
  input  logic [1:0]        req_speed,
  input  logic [1:0]        req_xfer,
  input  logic [1:0]        req_split,
  input  logic              req_dir_in,
  input  logic [1:0]        req_ntrans,
  input  logic [MPS_W-1:0]  req_mps,
  output logic              cost_valid,
  output logic              cost_err,
  output logic [COST_W-1:0] cost_bytes
);

  localparam int PAY_W = MPS_W + 1;

  cost_plan_t        plan_w;
  logic [PAY_W-1:0]  stuffed_w;
  logic [HD_W-1:0]   host_delay_q;

  // stage 1 state, named for the checker
  logic              pipe_s1_valid;
  logic              pipe_s1_err;
  logic [7:0]        s1_base;
  logic [3:0]        s1_pay_mul;
  logic [1:0]        s1_rep;
  logic [PAY_W-1:0]  s1_pay;
  logic [HD_W-1:0]   s1_hd;
  logic [COST_W-1:0] total_w;

  usb_bw_decode u_decode (
    .speed  (req_speed),
    .xfer   (req_xfer),
    .split  (req_split),
    .dir_in (req_dir_in),
    .ntrans (req_ntrans),
    .plan   (plan_w)
  );

  usb_bw_stuff #(.MPS_W(MPS_W)) u_stuff (
    .mps     (req_mps),
    .stuffed (stuffed_w)
  );

  usb_bw_hostdelay #(.HD_W(HD_W), .HD_RESET(HD_DEFAULT)) u_hd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (hd_wr_en),
    .wr_data (hd_wr_data),
    .delay_q (host_delay_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_s1_valid <= 1'b0;
      pipe_s1_err   <= 1'b0;
      s1_base       <= '0;
      s1_pay_mul    <= '0;
      s1_rep        <= '0;
      s1_pay        <= '0;
      s1_hd         <= '0;
    end else begin
      pipe_s1_valid <= req_valid;
      pipe_s1_err   <= req_valid && plan_w.err;
      if (req_valid) begin
        s1_base    <= plan_w.base;
        s1_pay_mul <= plan_w.pay_mul;
        s1_rep     <= plan_w.rep;
        s1_pay     <= stuffed_w;
        s1_hd      <= host_delay_q;  // value before any same-cycle write
      end
    end
  end

  assign total_w = COST_W'(cost_sum(32'(s1_base), 32'(s1_pay), 32'(s1_pay_mul),
                                    32'(s1_hd), 32'(s1_rep)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cost_valid <= 1'b0;
      cost_err   <= 1'b0;
      cost_bytes <= '0;
    end else begin
      cost_valid <= pipe_s1_valid;
      cost_err   <= pipe_s1_valid && pipe_s1_err;
      cost_bytes <= (pipe_s1_valid && !pipe_s1_err) ? total_w : '0;
    end
  end

endmodule

// File: rtl/usb_bw_cost_calc_chk.sv
module usb_bw_cost_calc_chk #(
  parameter int MPS_W  = 11,
  parameter int HD_W   = 8,
  parameter int COST_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_speed,
  input logic [1:0]        req_xfer,
  input logic              hd_wr_en,
  input logic [HD_W-1:0]   hd_wr_data,
  input logic [HD_W-1:0]   host_delay_q,
  input logic              pipe_s1_valid,
  input logic              pipe_s1_err,
  input logic              cost_valid,
  input logic              cost_err,
  input logic [COST_W-1:0] cost_bytes
);

  localparam int unsigned MPS_MAX  = (1 << MPS_W) - 1;
  localparam int unsigned COST_MAX = 98 + 8 * ((MPS_MAX * 7) / 6) + ((1 << HD_W) - 1);

  assert_req_enters_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> pipe_s1_valid);

  assert_result_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_s1_valid |=> cost_valid);

  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_s1_valid |=> !cost_valid);

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cost_valid |-> (cost_bytes == '0 && !cost_err));

  assert_cost_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cost_valid |-> (32'(cost_bytes) <= COST_MAX));

  assert_hd_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hd_wr_en |=> (host_delay_q == $past(hd_wr_data)));

  assert_hd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hd_wr_en |=> $stable(host_delay_q));

  assert_ls_iso_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_speed == 2'd1 && (req_xfer == 2'd1 || req_xfer == 2'd2)) |=> pipe_s1_err);

  assert_err_zero_cost_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_s1_valid && pipe_s1_err) |=> (cost_err && cost_bytes == '0));

endmodule

bind usb_bw_cost_calc usb_bw_cost_calc_chk #(
  .MPS_W(MPS_W), .HD_W(HD_W), .COST_W(COST_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_speed     (req_speed),
  .req_xfer      (req_xfer),
  .hd_wr_en      (hd_wr_en),
  .hd_wr_data    (hd_wr_data),
  .host_delay_q  (host_delay_q),
  .pipe_s1_valid (pipe_s1_valid),
  .pipe_s1_err   (pipe_s1_err),
  .cost_valid    (cost_valid),
  .cost_err      (cost_err),
  .cost_bytes    (cost_bytes)
);

// File: tb/usb_bw_cost_calc_tb.sv
module usb_bw_cost_calc_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hd_wr_en = 1'b0;
  logic [7:0]  hd_wr_data = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_speed = '0;
  logic [1:0]  req_xfer = '0;
  logic [1:0]  req_split = '0;
  logic        req_dir_in = 1'b0;
  logic [1:0]  req_ntrans = '0;
  logic [10:0] req_mps = '0;
  logic        cost_valid;
  logic        cost_err;
  logic [15:0] cost_bytes;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;
  int model_hd = 18;

  always #10 clk = ~clk;  // 50 MHz

  usb_bw_cost_calc dut_i (
    .clk(clk), .rst_n(rst_n), .hd_wr_en(hd_wr_en), .hd_wr_data(hd_wr_data),
    .req_valid(req_valid), .req_speed(req_speed), .req_xfer(req_xfer),
    .req_split(req_split), .req_dir_in(req_dir_in), .req_ntrans(req_ntrans),
    .req_mps(req_mps), .cost_valid(cost_valid), .cost_err(cost_err),
    .cost_bytes(cost_bytes)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      failures++;
      $display("FAIL watchdog: run did not end, actual cycles=%0d expected below 150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // Reference pricing, written from the requirements.
  function automatic int ref_cost(input int sp, input int xf, input int spl,
                                  input int din, input int nt, input int mps,
                                  input int hd, output bit bad);
    int stuffed = (mps * 7) / 6;
    bit iso = (xf == 1) || (xf == 2);
    bit inward = (xf == 2) || (xf == 0 && din != 0);
    int hs_ov = iso ? 38 : 55;
    bad = (sp == 3) || (xf == 3) || (spl == 3) || (sp == 1 && iso) ||
          (sp == 2 && (spl != 0 || nt == 0));
    if (bad) return 0;
    if (spl == 1) return hs_ov + hd + 4 + (inward ? 0 : stuffed);
    if (spl == 2) return hs_ov + hd + 4 + (inward ? stuffed : 0);
    if (sp == 2) return nt * (hs_ov + stuffed + hd);
    if (sp == 1) return 8 * stuffed + hd + 98;
    case (xf)
      1: return 10 + stuffed + hd;
      2: return 11 + stuffed + hd;
      default: return 14 + stuffed + hd;
    endcase
  endfunction

  function automatic string tag_of(input int sp, input int xf, input int spl,
                                   input int din, input int nt);
    bit iso = (xf == 1) || (xf == 2);
    bit bad = (sp == 3) || (xf == 3) || (spl == 3) || (sp == 1 && iso) ||
              (sp == 2 && (spl != 0 || nt == 0));
    bit inward = (xf == 2) || (xf == 0 && din != 0);
    if (bad) return "R9";
    if (spl != 0) return inward ? "R5" : "R6";
    if (sp == 2) return "R4";
    if (sp == 1) return "R3";
    return "R2";
  endfunction

  // One request; optional host-delay write in the same cycle.
  task automatic run_req(input int sp, input int xf, input int spl, input int din,
                         input int nt, input int mps, input bit wr, input int wdata,
                         input string tag_in, output int got);
    bit bad;
    int exp_c;
    string tag;
    exp_c = ref_cost(sp, xf, spl, din, nt, mps, model_hd, bad);
    tag = (tag_in.len() != 0) ? tag_in : tag_of(sp, xf, spl, din, nt);
    req_valid  = 1'b1;
    req_speed  = 2'(sp);
    req_xfer   = 2'(xf);
    req_split  = 2'(spl);
    req_dir_in = din[0];
    req_ntrans = 2'(nt);
    req_mps    = 11'(mps);
    hd_wr_en   = wr;
    hd_wr_data = 8'(wdata);
    @(negedge clk);
    req_valid = 1'b0;
    hd_wr_en  = 1'b0;
    if (wr) model_hd = wdata;
    check("R1 not early", int'(cost_valid), 0);
    @(negedge clk);
    check("R1 strobe", int'(cost_valid), 1);
    check({tag, " err"}, int'(cost_err), int'(bad));
    check({tag, " cost"}, int'(cost_bytes), exp_c);
    got = int'(cost_bytes);
    @(negedge clk);
    check("R1 one-cycle", int'(cost_valid), 0);
  endtask

  initial begin
    int g0, g1;
    int dummy;
    dummy = $urandom(32'h00C0FFEE);
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(cost_valid), 0);
    check("R1 reset cost", int'(cost_bytes), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: default delay, FS plain mps 64 -> 14+74+18
    run_req(0, 0, 0, 0, 1, 64, 0, 0, "R8 default", g0);
    check("R8 default value", g0, 106);
    // R2 iso variants
    run_req(0, 1, 0, 0, 1, 1023, 0, 0, "R2", g0);
    run_req(0, 2, 0, 0, 1, 1023, 0, 0, "R2", g0);
    // R3 low speed max-ish
    run_req(1, 0, 0, 0, 1, 8, 0, 0, "R3", g0);
    run_req(1, 0, 0, 0, 1, 2047, 0, 0, "R3", g0);
    // R4 high speed, 3 transactions, max packet
    run_req(2, 1, 0, 0, 3, 1024, 0, 0, "R4", g0);
    run_req(2, 0, 0, 0, 2, 512, 0, 0, "R4", g0);
    // R5 / R6 split phases
    run_req(0, 2, 1, 0, 1, 188, 0, 0, "R5 start", g0);
    run_req(0, 2, 2, 0, 1, 188, 0, 0, "R5 complete", g0);
    run_req(1, 0, 2, 1, 1, 8, 0, 0, "R5 ls complete", g0);
    run_req(0, 1, 1, 0, 1, 188, 0, 0, "R6 start", g0);
    run_req(0, 1, 2, 0, 1, 188, 0, 0, "R6 complete", g0);
    run_req(0, 0, 1, 0, 1, 64, 0, 0, "R6 plain start", g0);
    // R9 illegal combinations
    run_req(1, 1, 0, 0, 1, 8, 0, 0, "R9 ls iso", g0);
    run_req(2, 0, 0, 0, 0, 64, 0, 0, "R9 ntrans0", g0);
    run_req(2, 0, 1, 0, 1, 64, 0, 0, "R9 hs split", g0);
    run_req(3, 0, 0, 0, 1, 64, 0, 0, "R9 speed3", g0);
    run_req(0, 3, 0, 0, 1, 64, 0, 0, "R9 xfer3", g0);
    run_req(0, 0, 3, 0, 1, 64, 0, 0, "R9 split3", g0);
    // R10 ntrans and direction ignored where they do not apply
    run_req(0, 0, 0, 0, 0, 300, 0, 0, "R10 nt0", g0);
    run_req(0, 0, 0, 1, 3, 300, 0, 0, "R10 nt3 dir1", g1);
    check("R10 same cost", g1, g0);
    run_req(0, 1, 2, 0, 2, 99, 0, 0, "R10 iso dir0", g0);
    run_req(0, 1, 2, 1, 0, 99, 0, 0, "R10 iso dir1", g1);
    check("R10 iso dir same", g1, g0);
    // R8 same-cycle write: old value used, new value next
    run_req(0, 0, 0, 0, 1, 10, 1, 200, "R8 same-cycle", g0);
    check("R8 old delay used", g0, 14 + 11 + 18);
    run_req(0, 0, 0, 0, 1, 10, 0, 0, "R8 new delay", g0);
    check("R8 new delay used", g0, 14 + 11 + 200);
    run_req(2, 0, 0, 0, 3, 2047, 1, 255, "R8 max hd", g0);
    run_req(1, 0, 0, 0, 1, 2047, 0, 0, "R8 max ls", g0);
    check("R3 ls max", g0, 98 + 8 * 2388 + 255);
    run_req(0, 0, 0, 0, 1, 0, 1, 0, "R8 zero hd", g0);

    // R7: every 11-bit packet size, full speed plain
    for (int m = 0; m < 2048; m++) run_req(0, 0, 0, 0, 1, m, 0, 0, "R7", g0);

    // random mix with occasional same-cycle delay writes
    for (int i = 0; i < 3000; i++) begin
      int sp = ($urandom % 8 == 0) ? 3 : int'($urandom % 3);
      int xf = ($urandom % 10 == 0) ? 3 : int'($urandom % 3);
      int spl = ($urandom % 12 == 0) ? 3 : int'($urandom % 3);
      int nt = int'($urandom % 4);
      int din = int'($urandom % 2);
      int mps = int'($urandom % 2048);
      bit wr = ($urandom % 6 == 0);
      int wd = int'($urandom % 256);
      if (sp == 2 && $urandom % 4 != 0) spl = 0;
      if (sp == 1 && $urandom % 3 != 0) xf = 0;
      run_req(sp, xf, spl, din, nt, mps, wr, wd, "", g0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule